// File: doc/BRIEF.md
# Dual-Page Address Translation Buffer

This block is a fully associative translation buffer that turns a 32-bit virtual address into a physical address for one load or store at a time. Each of its entries covers a naturally aligned pair of adjacent 4 KB pages. An entry stores one virtual tag for the pair, an 8-bit address-space identifier, a global flag and two frame descriptors. The frame for the even page and the frame for the odd page each carry their own frame number, a valid bit and a dirty (writable) bit.

A request presents the address, the access direction and the current address-space identifier. Every entry compares against it in parallel. The lowest-numbered matching entry supplies the frame, chosen by address bit 12. One cycle later the block returns a registered outcome code, the physical address and the read and write permissions, marked by a response strobe. Software or a refill engine loads entries through an indexed write port. A write lands at the clock edge, so a lookup in the same cycle still sees the old contents.

Top module: `pagepair_xlate`

## Requirements
- R1: During reset and after it, rsp_valid is low until a request arrives. Reset removes every entry, so each lookup after reset returns the miss code (1) with zero address and no permissions until entries are written.
- R2: A request with req_valid high in a cycle produces rsp_valid high in the next cycle only. The response registers change only on a request.
- R3: An entry matches when its stored tag equals virtual address bits 31:13 and either its global flag is set or its stored identifier equals cur_asid. Bits 12:0 play no part in the match.
- R4: When several entries match, the entry with the lowest index decides the result.
- R5: Address bit 12 selects the odd frame (1) or the even frame (0). On success, rsp_paddr is {frame number, vaddr[11:0]}.
- R6: A load to a matching entry whose selected frame is valid returns code 0 (hit) with rsp_can_read = 1 and rsp_can_write equal to the frame's dirty bit.
- R7: A store to a valid frame whose dirty bit is set returns code 0 with both permissions 1.
- R8: A store to a valid frame whose dirty bit is clear returns code 3 (modified), with zero address and both permissions 0. Every non-hit outcome returns zero address and no permissions.
- R9: A match whose selected frame is not valid returns code 2 (invalid) for both loads and stores.
- R10: When no entry matches, the result is code 1 (miss).
- R11: An entry write updates the entry at the next clock edge. A lookup in the same cycle sees the old contents, and the following lookup sees the new ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space identifier |
| wr_en | input | 1 | Entry write strobe |
| wr_index | input | 4 | Entry to write |
| wr_tag | input | 19 | Page-pair tag (virtual address bits 31:13) |
| wr_asid | input | 8 | Identifier stored in the entry |
| wr_global | input | 1 | Entry matches under any identifier |
| wr_even_pfn | input | 20 | Even-page frame number |
| wr_even_valid | input | 1 | Even frame valid |
| wr_even_dirty | input | 1 | Even frame writable |
| wr_odd_pfn | input | 20 | Odd-page frame number |
| wr_odd_valid | input | 1 | Odd frame valid |
| wr_odd_dirty | input | 1 | Odd frame writable |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_code | output | 2 | 0 hit, 1 miss, 2 invalid, 3 modified |
| rsp_paddr | output | 32 | Translated physical address (zero unless hit) |
| rsp_can_read | output | 1 | Read permitted |
| rsp_can_write | output | 1 | Write permitted |

## Verification
The assertions assume that the request and write inputs carry known values in every cycle after reset is released. They also assume that wr_index never names an entry beyond the last one. Without this, the grant vector and the selected frame could be unknown. The bench drives every input from time zero on the falling clock edge, and it writes only indices 0 to 15. Each request lasts one cycle, so every response can be tied to the single request that came before it.

// File: rtl/pagepair_pkg.sv
package pagepair_pkg;
  localparam int VA_W      = 32;
  localparam int PAGE_BITS = 12;
  localparam int PFN_W     = 20;
  localparam int ASID_W    = 8;
  localparam int TAG_W     = VA_W - PAGE_BITS - 1;
  localparam int PA_W      = PFN_W + PAGE_BITS;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             valid;
    logic             dirty;
  } pp_frame_t;

  typedef struct packed {
    logic              present;
    logic [TAG_W-1:0]  tag;
    logic [ASID_W-1:0] asid;
    logic              glob;
    pp_frame_t         even_f;
    pp_frame_t         odd_f;
  } pp_entry_t;

  typedef enum logic [1:0] {
    XL_HIT      = 2'd0,
    XL_MISS     = 2'd1,
    XL_INVALID  = 2'd2,
    XL_MODIFIED = 2'd3
  } xl_code_e;

  function automatic logic [TAG_W-1:0] pair_tag(input logic [VA_W-1:0] va);
    return va[VA_W-1:PAGE_BITS+1];
  endfunction

  function automatic logic odd_half(input logic [VA_W-1:0] va);
    return va[PAGE_BITS];
  endfunction

  function automatic logic [PA_W-1:0] join_paddr(input logic [PFN_W-1:0] pfn,
                                                 input logic [VA_W-1:0] va);
    return {pfn, va[PAGE_BITS-1:0]};
  endfunction
endpackage

// File: rtl/pp_entry_store.sv
module pp_entry_store
  import pagepair_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_index,
  input  pp_entry_t        wr_entry,
  output pp_entry_t        table_q [ENTRIES]
);
  // One register per entry; reset clears presence and both frame valid bits.
  for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        table_q[e] <= '0;
      else if (wr_en && wr_index == IDX_W'(e))
        table_q[e] <= wr_entry;
    end
  end
endmodule

// File: rtl/pp_match_array.sv
module pp_match_array
  import pagepair_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  pp_entry_t          table_q [ENTRIES],
  input  logic [TAG_W-1:0]   look_tag,
  input  logic [ASID_W-1:0]  look_asid,
  output logic [ENTRIES-1:0] match_vec,
  output logic [ENTRIES-1:0] grant_vec,
  output logic [IDX_W-1:0]   hit_idx,
  output logic               hit_any
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match_vec[e] = table_q[e].present &&
                          (table_q[e].tag == look_tag) &&
                          (table_q[e].glob || (table_q[e].asid == look_asid));
  end

  // Walk from the top down so the lowest matching index is left standing.
  always_comb begin
    hit_idx   = '0;
    grant_vec = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_vec[e]) begin
        hit_idx   = IDX_W'(e);
        grant_vec = ENTRIES'(1) << e;
      end
    end
  end

  assign hit_any = |match_vec;
endmodule

// File: rtl/pagepair_xlate.sv
module pagepair_xlate
  import pagepair_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PFN_W-1:0]  wr_even_pfn,
  input  logic              wr_even_valid,
  input  logic              wr_even_dirty,
  input  logic [PFN_W-1:0]  wr_odd_pfn,
  input  logic              wr_odd_valid,
  input  logic              wr_odd_dirty,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_can_read,
  output logic              rsp_can_write
);
  pp_entry_t          wr_entry;
  pp_entry_t          table_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] grant_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic               hit_any;
  pp_entry_t          sel_entry;
  pp_frame_t          sel_frame;
  xl_code_e           nxt_code;
  logic [PA_W-1:0]    nxt_paddr;
  logic               nxt_rd;
  logic               nxt_wr;

  always_comb begin
    wr_entry.present      = 1'b1;
    wr_entry.tag          = wr_tag;
    wr_entry.asid         = wr_asid;
    wr_entry.glob         = wr_global;
    wr_entry.even_f.pfn   = wr_even_pfn;
    wr_entry.even_f.valid = wr_even_valid;
    wr_entry.even_f.dirty = wr_even_dirty;
    wr_entry.odd_f.pfn    = wr_odd_pfn;
    wr_entry.odd_f.valid  = wr_odd_valid;
    wr_entry.odd_f.dirty  = wr_odd_dirty;
  end

  pp_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_index (wr_index),
    .wr_entry (wr_entry),
    .table_q  (table_q)
  );

  pp_match_array #(.ENTRIES(ENTRIES)) u_match (
    .table_q   (table_q),
    .look_tag  (pair_tag(req_vaddr)),
    .look_asid (cur_asid),
    .match_vec (match_vec),
    .grant_vec (grant_vec),
    .hit_idx   (hit_idx),
    .hit_any   (hit_any)
  );

  assign sel_entry = table_q[hit_idx];
  assign sel_frame = odd_half(req_vaddr) ? sel_entry.odd_f : sel_entry.even_f;

  always_comb begin
    nxt_code  = XL_MISS;
    nxt_paddr = '0;
    nxt_rd    = 1'b0;
    nxt_wr    = 1'b0;
    if (hit_any) begin
      if (!sel_frame.valid) begin
        nxt_code = XL_INVALID;
      end else if (req_write && !sel_frame.dirty) begin
        nxt_code = XL_MODIFIED;
      end else begin
        nxt_code  = XL_HIT;
        nxt_paddr = join_paddr(sel_frame.pfn, req_vaddr);
        nxt_rd    = 1'b1;
        nxt_wr    = sel_frame.dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_code      <= XL_MISS;
      rsp_paddr     <= '0;
      rsp_can_read  <= 1'b0;
      rsp_can_write <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_code      <= nxt_code;
        rsp_paddr     <= nxt_paddr;
        rsp_can_read  <= nxt_rd;
        rsp_can_write <= nxt_wr;
      end
    end
  end

  // R2: the strobe answers exactly the request one cycle earlier.
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  a_r2_req_gets_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R4: the priority logic grants at most one entry, never above a lower match.
  a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec));
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_vec - ENTRIES'(1)) & match_vec) == '0);

  // R5: a hit keeps the page offset of the requesting address.
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == XL_HIT) |-> rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]));

  // R6: write permission never comes without read permission.
  a_r6_write_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_can_write |-> rsp_can_read);

  // R8: failures grant nothing; the modified outcome only answers a store.
  a_r8_fail_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != XL_HIT) |-> (!rsp_can_read && !rsp_can_write && rsp_paddr == '0));
  a_r8_modified_is_store: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == XL_MODIFIED) |-> $past(req_write));
endmodule

// File: tb/pagepair_xlate_bench.sv
module pagepair_xlate_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  cur_asid = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_index = '0;
  logic [18:0] wr_tag = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_global = 1'b0;
  logic [19:0] wr_even_pfn = '0;
  logic        wr_even_valid = 1'b0;
  logic        wr_even_dirty = 1'b0;
  logic [19:0] wr_odd_pfn = '0;
  logic        wr_odd_valid = 1'b0;
  logic        wr_odd_dirty = 1'b0;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_paddr;
  logic        rsp_can_read;
  logic        rsp_can_write;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pagepair_xlate u_pagepair_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .cur_asid(cur_asid), .wr_en(wr_en), .wr_index(wr_index),
    .wr_tag(wr_tag), .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_even_pfn(wr_even_pfn), .wr_even_valid(wr_even_valid), .wr_even_dirty(wr_even_dirty),
    .wr_odd_pfn(wr_odd_pfn), .wr_odd_valid(wr_odd_valid), .wr_odd_dirty(wr_odd_dirty),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .rsp_can_read(rsp_can_read), .rsp_can_write(rsp_can_write)
  );

  typedef struct packed {
    logic        st;
    logic [31:0] va;
    logic [7:0]  asid;
    logic [1:0]  code;
    logic [31:0] pa;
    logic        rd;
    logic        wp;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h0002_0123, 8'd5,   2'd0, 32'h1111_1123, 1'b1, 1'b1},  // R6 even, dirty
    '{1'b1, 32'h0002_0123, 8'd5,   2'd0, 32'h1111_1123, 1'b1, 1'b1},  // R7
    '{1'b0, 32'h0002_1ABC, 8'd5,   2'd0, 32'h2222_2ABC, 1'b1, 1'b0},  // R5 odd, clean load
    '{1'b1, 32'h0002_1ABC, 8'd5,   2'd3, 32'h0,         1'b0, 1'b0},  // R8
    '{1'b0, 32'h0002_0004, 8'd7,   2'd0, 32'h5555_5004, 1'b1, 1'b1},  // R3 asid picks entry 2
    '{1'b0, 32'h0002_0004, 8'd3,   2'd1, 32'h0,         1'b0, 1'b0},  // R10 asid mismatch
    '{1'b0, 32'h0004_0010, 8'd3,   2'd2, 32'h0,         1'b0, 1'b0},  // R9 load
    '{1'b1, 32'h0004_0010, 8'd200, 2'd2, 32'h0,         1'b0, 1'b0},  // R9 store
    '{1'b1, 32'h0004_1FFF, 8'd200, 2'd0, 32'h4444_4FFF, 1'b1, 1'b1},  // R3 global
    '{1'b0, 32'h8000_0FF0, 8'd1,   2'd0, 32'h0ABC_DFF0, 1'b1, 1'b1},  // R4 entry 4 over 9
    '{1'b0, 32'hFFFF_F001, 8'd9,   2'd0, 32'hFFFF_F001, 1'b1, 1'b0},  // R5 top of space
    '{1'b1, 32'hFFFF_F001, 8'd9,   2'd3, 32'h0,         1'b0, 1'b0},  // R8
    '{1'b0, 32'hFFFF_F001, 8'd8,   2'd1, 32'h0,         1'b0, 1'b0},  // R10
    '{1'b0, 32'h0006_0000, 8'd5,   2'd0, 32'h7777_7000, 1'b1, 1'b1},  // R5 offset 0
    '{1'b0, 32'h0006_1FFF, 8'd5,   2'd0, 32'h0000_1FFF, 1'b1, 1'b1},  // R5 offset max
    '{1'b0, 32'h0008_0000, 8'd5,   2'd1, 32'h0,         1'b0, 1'b0},  // R10
    '{1'b0, 32'h0002_2000, 8'd5,   2'd1, 32'h0,         1'b0, 1'b0}   // R3 bit 13 counts
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic load_entry(input logic [3:0] idx, input logic [18:0] tag,
                            input logic [7:0] asid, input logic g,
                            input logic [19:0] epfn, input logic ev, input logic ed,
                            input logic [19:0] opfn, input logic ov, input logic od);
    @(negedge clk);
    wr_en = 1'b1; wr_index = idx; wr_tag = tag; wr_asid = asid; wr_global = g;
    wr_even_pfn = epfn; wr_even_valid = ev; wr_even_dirty = ed;
    wr_odd_pfn = opfn; wr_odd_valid = ov; wr_odd_dirty = od;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic st, input logic [31:0] va, input logic [7:0] asid);
    @(negedge clk);
    req_valid = 1'b1; req_write = st; req_vaddr = va; cur_asid = asid;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);

    // Empty buffer: every lookup misses.
    lookup(1'b0, 32'h0002_0123, 8'd5);
    check("R1", "code empty", 64'(rsp_code), 64'd1);
    check("R1", "paddr empty", 64'(rsp_paddr), 64'd0);
    lookup(1'b1, 32'h8000_0000, 8'd0);
    check("R1", "code empty 2", 64'(rsp_code), 64'd1);
    check("R1", "perms empty", 64'({rsp_can_read, rsp_can_write}), 64'd0);

    load_entry(4'd0,  19'h00010, 8'd5, 1'b0, 20'h11111, 1'b1, 1'b1, 20'h22222, 1'b1, 1'b0);
    load_entry(4'd1,  19'h00020, 8'd0, 1'b1, 20'h33333, 1'b0, 1'b0, 20'h44444, 1'b1, 1'b1);
    load_entry(4'd2,  19'h00010, 8'd7, 1'b0, 20'h55555, 1'b1, 1'b1, 20'h66666, 1'b1, 1'b1);
    load_entry(4'd3,  19'h00030, 8'd5, 1'b0, 20'h77777, 1'b1, 1'b1, 20'h00001, 1'b1, 1'b1);
    load_entry(4'd4,  19'h40000, 8'd0, 1'b1, 20'h0ABCD, 1'b1, 1'b1, 20'h0,     1'b0, 1'b0);
    load_entry(4'd9,  19'h40000, 8'd0, 1'b1, 20'h0DCBA, 1'b1, 1'b1, 20'h0,     1'b0, 1'b0);
    load_entry(4'd15, 19'h7FFFF, 8'd9, 1'b0, 20'h0,     1'b0, 1'b0, 20'hFFFFF, 1'b1, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].st, VECS[i].va, VECS[i].asid);
      check("R2", $sformatf("rsp_valid vec %0d", i), 64'(rsp_valid), 64'd1);
      check("R3-R10", $sformatf("code vec %0d", i), 64'(rsp_code), 64'(VECS[i].code));
      check("R5", $sformatf("paddr vec %0d", i), 64'(rsp_paddr), 64'(VECS[i].pa));
      check("R6", $sformatf("perms vec %0d", i), 64'({rsp_can_read, rsp_can_write}),
            64'({VECS[i].rd, VECS[i].wp}));
    end

    // R2: an idle cycle gives no strobe and keeps the last response.
    @(negedge clk);
    check("R2", "idle rsp_valid", 64'(rsp_valid), 64'd0);
    check("R2", "idle code held", 64'(rsp_code), 64'd1);

    // R11: write and lookup in one cycle; the lookup sees the old frame.
    @(negedge clk);
    wr_en = 1'b1; wr_index = 4'd3; wr_tag = 19'h00030; wr_asid = 8'd5; wr_global = 1'b0;
    wr_even_pfn = 20'h12345; wr_even_valid = 1'b1; wr_even_dirty = 1'b0;
    wr_odd_pfn = 20'h00001; wr_odd_valid = 1'b1; wr_odd_dirty = 1'b1;
    req_valid = 1'b1; req_write = 1'b0; req_vaddr = 32'h0006_0000; cur_asid = 8'd5;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    check("R11", "same-cycle old paddr", 64'(rsp_paddr), 64'h7777_7000);
    check("R11", "same-cycle old perms", 64'({rsp_can_read, rsp_can_write}), 64'd3);
    lookup(1'b0, 32'h0006_0000, 8'd5);
    check("R11", "next lookup new paddr", 64'(rsp_paddr), 64'h1234_5000);
    check("R6", "new clean load perms", 64'({rsp_can_read, rsp_can_write}), 64'd2);
    lookup(1'b1, 32'h0006_0000, 8'd5);
    check("R8", "store to rewritten clean", 64'(rsp_code), 64'd3);

    // R4: lower entry with invalid frame still decides over a valid higher one.
    load_entry(4'd5, 19'h00050, 8'd0, 1'b1, 20'h0, 1'b0, 1'b0, 20'h0, 1'b0, 1'b0);
    load_entry(4'd6, 19'h00050, 8'd0, 1'b1, 20'h0BEEF, 1'b1, 1'b1, 20'h0, 1'b0, 1'b0);
    lookup(1'b0, 32'h000A_0000, 8'd0);
    check("R4", "low invalid entry wins", 64'(rsp_code), 64'd2);

    finish_run();
  end
endmodule